// File: doc/BRIEF.md
# Transmit Completion Status Stack

This block keeps a record of finished transmissions so that host software can inspect them one at a time. Each time the transmitter finishes a frame it presents a one-cycle completion strobe with four flags: an interrupt request made for that frame, a jabber error, an underrun error and a maximum-collision abort. The block stores these outcomes in arrival order, up to `DEPTH` entries. The host sees an 8-bit status byte that describes the oldest entry not yet removed. The host removes that entry by writing the status register, which is modelled here as a one-cycle `host_pop` strobe. Looking at the status byte does not remove anything.

When a completion arrives while every slot is occupied and no pop happens in the same cycle, the new completion is dropped. The loss is then reported in-band by setting an overflow bit on the newest stored entry. A jabber or an underrun completion switches the transmitter off. It stays off until the host issues a transmit reset. A registered cause pulse goes to the interrupt logic for every completion that carries a flag.

Occupancy is tracked by a three-state machine. The states are EMPTY, PARTIAL and FULL, and the transitions are fill_first, fill_last, drain_one and drain_last. The fill_first transition leaves EMPTY on a store. It goes to PARTIAL, or straight to FULL when `DEPTH` is 1. The fill_last transition moves from PARTIAL to FULL when the last free slot is taken. The drain_one transition leaves FULL on a pop without a store. It goes to PARTIAL, or to EMPTY when `DEPTH` is 1. The drain_last transition moves from PARTIAL to EMPTY when the last entry is popped.

Top module: `txdone_stack`

## Requirements
- R1: The status byte has this layout: bit 7 set marks a valid entry, bit 6 is the interrupt request, bit 5 is jabber, bit 4 is underrun, bit 3 is maximum collisions, bit 2 is overflow, and bits 1 and 0 always read 0.
- R2: The status byte always shows the oldest entry that has not been popped. Entries leave in the order they arrived, and the byte is combinational from the stored head.
- R3: A `host_pop` pulse removes the oldest entry. The next entry, or 0x00 if none is left, is visible from the cycle after the pop.
- R4: While the store is empty, the status byte reads 0x00 and `host_pop` is ignored. A later completion is then stored and shown normally.
- R5: The store holds `DEPTH` entries. A completion that arrives while the store is full and no pop happens is dropped. In that case bit 2 is set on the newest stored entry and the other entries are unchanged.
- R6: A completion and a pop in the same cycle while full are handled pop first. The new entry is stored and no overflow is marked.
- R7: A completion with jabber or underrun drives `tx_enabled` low from the next cycle. It stays low until a `tx_reset` pulse, which raises it the cycle after. If an error completion coincides with `tx_reset`, the disable wins.
- R8: A completion with only the interrupt-request flag or the maximum-collision flag set leaves `tx_enabled` unchanged.
- R9: `txc_cause` is high for exactly the one cycle after each completion strobe that has any of the four flags set. A completion with no flags, and any cycle without a completion, gives no pulse.
- R10: After reset the store is empty (status byte 0x00), `tx_enabled` is 1 and `txc_cause` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| done_valid | input | 1 | One-cycle strobe: a transmission finished |
| done_irq_req | input | 1 | Interrupt on completion was requested for the frame |
| done_jabber | input | 1 | Frame ended with a jabber error |
| done_underrun | input | 1 | Frame ended with a data underrun |
| done_maxcoll | input | 1 | Frame aborted after maximum collisions |
| host_pop | input | 1 | Host write to the status register; pops the oldest entry |
| tx_reset | input | 1 | Transmit reset; re-enables the transmitter |
| status_byte | output | 8 | Status of the oldest unpopped entry, 0x00 when empty |
| tx_enabled | output | 1 | Transmitter allowed to run |
| txc_cause | output | 1 | Registered pulse for a completion with any flag |

## Verification
The bench fills the store exactly to `DEPTH` and then pushes one more entry. A design that overwrote the oldest slot would lose the head, and a design that flagged the wrong slot would show bit 2 on the wrong pop. A pop and a push arrive together while the store is full. A design that evaluated the push before the pop would drop the new entry and mark a spurious overflow. A pop on an empty store is followed by a normal push and drain, which exposes a count that wrapped below zero. The disable latch is driven with an error and a reset in the same cycle, where giving the reset priority would leave the transmitter running after a jabber.

// File: rtl/txs_pkg.sv
package txs_pkg;

    typedef struct packed {
        logic irq;
        logic jab;
        logic und;
        logic mcol;
        logic ovf;
    } txs_entry_t;

    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_PARTIAL = 2'd1,
        ST_FULL    = 2'd2
    } occ_state_t;

endpackage

// File: rtl/txs_ctrl.sv
module txs_ctrl
    import txs_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          done_valid,
    input  logic          host_pop,
    output logic          push_ok,
    output logic          pop_ok,
    output logic          ovf_mark,
    output logic [CW-1:0] occ,
    output occ_state_t    state
);

    occ_state_t    state_nx;
    logic [CW-1:0] occ_nx;

    // outputs: pop is evaluated first, so a full store accepts a push with a pop
    always_comb begin
        pop_ok   = host_pop && (state != ST_EMPTY);
        push_ok  = done_valid && ((state != ST_FULL) || host_pop);
        ovf_mark = done_valid && (state == ST_FULL) && !host_pop;
        occ_nx   = occ + CW'(push_ok) - CW'(pop_ok);
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_EMPTY: begin
                // fill_first
                if (push_ok)
                    state_nx = (occ_nx == CW'(DEPTH)) ? ST_FULL : ST_PARTIAL;
            end
            ST_PARTIAL: begin
                // fill_last / drain_last
                if (occ_nx == CW'(DEPTH))
                    state_nx = ST_FULL;
                else if (occ_nx == '0)
                    state_nx = ST_EMPTY;
            end
            ST_FULL: begin
                // drain_one
                if (pop_ok && !push_ok)
                    state_nx = (occ_nx == '0) ? ST_EMPTY : ST_PARTIAL;
            end
            default: state_nx = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_EMPTY;
            occ   <= '0;
        end else begin
            state <= state_nx;
            occ   <= occ_nx;
        end
    end

endmodule

// File: rtl/txs_store.sv
module txs_store
    import txs_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push_ok,
    input  logic       pop_ok,
    input  logic       ovf_mark,
    input  txs_entry_t new_entry,
    output txs_entry_t head
);

    logic [PW-1:0] wr_ptr, rd_ptr, last_ptr;
    txs_entry_t    slot [DEPTH];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign last_ptr = (wr_ptr == '0) ? PW'(DEPTH - 1) : wr_ptr - PW'(1);
    assign head     = slot[rd_ptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop_ok)  rd_ptr <= bump(rd_ptr);
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                slot[i] <= '0;
            else if (push_ok && wr_ptr == PW'(i))
                slot[i] <= new_entry;
            else if (ovf_mark && last_ptr == PW'(i))
                slot[i].ovf <= 1'b1;
        end
    end

endmodule

// File: rtl/txs_guard.sv
module txs_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic done_valid,
    input  logic done_irq_req,
    input  logic done_jabber,
    input  logic done_underrun,
    input  logic done_maxcoll,
    input  logic tx_reset,
    output logic tx_enabled,
    output logic txc_cause
);

    logic fatal, flagged;

    always_comb begin
        fatal   = done_valid && (done_jabber || done_underrun);
        flagged = done_valid &&
                  (done_irq_req || done_jabber || done_underrun || done_maxcoll);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_enabled <= 1'b1;
            txc_cause  <= 1'b0;
        end else begin
            txc_cause <= flagged;
            if (fatal)
                tx_enabled <= 1'b0;
            else if (tx_reset)
                tx_enabled <= 1'b1;
        end
    end

endmodule

// File: rtl/txdone_stack.sv
module txdone_stack
    import txs_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       done_valid,
    input  logic       done_irq_req,
    input  logic       done_jabber,
    input  logic       done_underrun,
    input  logic       done_maxcoll,
    input  logic       host_pop,
    input  logic       tx_reset,
    output logic [7:0] status_byte,
    output logic       tx_enabled,
    output logic       txc_cause
);

    logic          push_ok, pop_ok, ovf_mark;
    logic [CW-1:0] occ;
    occ_state_t    state;
    txs_entry_t    head, new_entry;

    assign new_entry = '{irq: done_irq_req, jab: done_jabber, und: done_underrun,
                         mcol: done_maxcoll, ovf: 1'b0};

    txs_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .done_valid(done_valid), .host_pop(host_pop),
        .push_ok(push_ok), .pop_ok(pop_ok), .ovf_mark(ovf_mark),
        .occ(occ), .state(state)
    );

    txs_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .push_ok(push_ok), .pop_ok(pop_ok),
        .ovf_mark(ovf_mark), .new_entry(new_entry), .head(head)
    );

    txs_guard u_guard (
        .clk(clk), .rst_n(rst_n), .done_valid(done_valid),
        .done_irq_req(done_irq_req), .done_jabber(done_jabber),
        .done_underrun(done_underrun), .done_maxcoll(done_maxcoll),
        .tx_reset(tx_reset), .tx_enabled(tx_enabled), .txc_cause(txc_cause)
    );

    always_comb begin
        if (state == ST_EMPTY)
            status_byte = 8'h00;
        else
            status_byte = {1'b1, head.irq, head.jab, head.und, head.mcol, head.ovf, 2'b00};
    end

endmodule

// File: rtl/txdone_stack_chk.sv
module txdone_stack_chk #(
    parameter int DEPTH = 4,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          done_valid,
    input logic          done_irq_req,
    input logic          done_jabber,
    input logic          done_underrun,
    input logic          done_maxcoll,
    input logic          host_pop,
    input logic [7:0]    status_byte,
    input logic          tx_enabled,
    input logic          txc_cause,
    input logic [CW-1:0] occ
);

    // R1
    low_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_byte[1:0] == 2'b00);

    // R4
    empty_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !status_byte[7] |-> status_byte == 8'h00);

    // R5
    occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CW'(DEPTH));

    // R5
    drop_keeps_occ_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == CW'(DEPTH) && done_valid && !host_pop) |=> $stable(occ));

    // R7
    error_disables_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && (done_jabber || done_underrun)) |=> !tx_enabled);

    // R8
    disable_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_enabled) |-> $past(done_valid && (done_jabber || done_underrun)));

    // R9
    cause_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && (done_irq_req || done_jabber || done_underrun || done_maxcoll))
        |=> txc_cause);

    // R9
    no_spurious_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_valid && (done_irq_req || done_jabber || done_underrun || done_maxcoll))
        |=> !txc_cause);

endmodule

bind txdone_stack txdone_stack_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .done_valid(done_valid),
    .done_irq_req(done_irq_req), .done_jabber(done_jabber),
    .done_underrun(done_underrun), .done_maxcoll(done_maxcoll),
    .host_pop(host_pop), .status_byte(status_byte),
    .tx_enabled(tx_enabled), .txc_cause(txc_cause), .occ(occ)
);

// File: tb/txdone_stack_test.sv
module txdone_stack_test;

    localparam int DEPTH = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       done_valid = 0, done_irq_req = 0, done_jabber = 0;
    logic       done_underrun = 0, done_maxcoll = 0, host_pop = 0, tx_reset = 0;
    logic [7:0] status_byte;
    logic       tx_enabled, txc_cause;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    txdone_stack #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .done_valid(done_valid),
        .done_irq_req(done_irq_req), .done_jabber(done_jabber),
        .done_underrun(done_underrun), .done_maxcoll(done_maxcoll),
        .host_pop(host_pop), .tx_reset(tx_reset),
        .status_byte(status_byte), .tx_enabled(tx_enabled), .txc_cause(txc_cause)
    );

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, actual, expected);
        end
    endtask

    // one cycle of stimulus applied at a falling edge, results seen at the next one
    task automatic drive(input logic v, input logic irq, input logic jab,
                         input logic und, input logic mc, input logic pop,
                         input logic trst);
        done_valid = v; done_irq_req = irq; done_jabber = jab;
        done_underrun = und; done_maxcoll = mc; host_pop = pop; tx_reset = trst;
        @(negedge clk);
        done_valid = 0; done_irq_req = 0; done_jabber = 0;
        done_underrun = 0; done_maxcoll = 0; host_pop = 0; tx_reset = 0;
    endtask

    task automatic pop_expect(input string req, input int exp_byte);
        check(req, status_byte, exp_byte);
        drive(0, 0, 0, 0, 0, 1, 0);
    endtask

    task automatic t_reset_state();
        check("R10 status", status_byte, 8'h00);
        check("R10 tx_enabled", tx_enabled, 1);
        check("R10 cause", txc_cause, 0);
    endtask

    task automatic t_layout();
        drive(1, 1, 0, 0, 0, 0, 0);
        check("R1 irq byte", status_byte, 8'hC0);
        check("R9 cause irq", txc_cause, 1);
        drive(1, 0, 0, 0, 1, 0, 0);
        check("R2 head kept", status_byte, 8'hC0);
        drive(1, 0, 0, 0, 0, 0, 0);
        check("R9 no cause plain", txc_cause, 0);
        check("R8 maxcoll keeps tx", tx_enabled, 1);
        pop_expect("R3 pop1", 8'hC0);
        pop_expect("R1 maxcoll byte", 8'h88);
        pop_expect("R1 plain byte", 8'h80);
        check("R3 drained", status_byte, 8'h00);
        check("R9 idle no cause", txc_cause, 0);
    endtask

    task automatic t_empty_pop();
        drive(0, 0, 0, 0, 0, 1, 0);
        check("R4 empty after pop", status_byte, 8'h00);
        drive(1, 1, 0, 0, 1, 0, 0);
        check("R4 push after empty pop", status_byte, 8'hC8);
        drive(0, 0, 0, 0, 0, 1, 0);
        check("R4 empty again", status_byte, 8'h00);
    endtask

    task automatic t_overflow();
        drive(1, 0, 0, 0, 1, 0, 0);
        drive(1, 1, 0, 0, 0, 0, 0);
        drive(1, 0, 0, 0, 0, 0, 0);
        drive(1, 1, 0, 0, 1, 0, 0);
        drive(1, 1, 0, 0, 0, 0, 0);
        check("R5 head after drop", status_byte, 8'h88);
        pop_expect("R5 e0", 8'h88);
        pop_expect("R5 e1", 8'hC0);
        pop_expect("R5 e2", 8'h80);
        pop_expect("R5 newest marked", 8'hCC);
        check("R5 dropped absent", status_byte, 8'h00);
    endtask

    task automatic t_full_push_pop();
        drive(1, 0, 0, 0, 1, 0, 0);
        drive(1, 1, 0, 0, 0, 0, 0);
        drive(1, 0, 0, 0, 0, 0, 0);
        drive(1, 1, 0, 0, 0, 0, 0);
        drive(1, 0, 0, 0, 1, 1, 0);
        check("R6 head advanced", status_byte, 8'hC0);
        pop_expect("R6 e1", 8'hC0);
        pop_expect("R6 e2", 8'h80);
        pop_expect("R6 e3", 8'hC0);
        pop_expect("R6 new no ovf", 8'h88);
        check("R6 drained", status_byte, 8'h00);
    endtask

    task automatic t_disable();
        drive(1, 0, 1, 0, 0, 0, 0);
        check("R7 jabber off", tx_enabled, 0);
        check("R1 jabber byte", status_byte, 8'hA0);
        drive(0, 0, 0, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 0, 0, 0);
        check("R7 stays off", tx_enabled, 0);
        drive(0, 0, 0, 0, 0, 0, 1);
        check("R7 reset on", tx_enabled, 1);
        drive(1, 0, 0, 1, 0, 0, 0);
        check("R7 underrun off", tx_enabled, 0);
        check("R9 cause underrun", txc_cause, 1);
        drive(1, 0, 1, 0, 0, 0, 1);
        check("R7 error beats reset", tx_enabled, 0);
        drive(0, 0, 0, 0, 0, 0, 1);
        check("R7 reset on again", tx_enabled, 1);
        pop_expect("R1 jabber pop", 8'hA0);
        pop_expect("R1 underrun byte", 8'h90);
        pop_expect("R1 jabber2 byte", 8'hA0);
        drive(1, 1, 0, 0, 1, 0, 0);
        check("R8 irq maxcoll keeps tx", tx_enabled, 1);
        pop_expect("R8 entry", 8'hC8);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_layout();
        t_empty_pop();
        t_overflow();
        t_full_push_pop();
        t_disable();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule